// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This block turns the few attribute bits found in a translation descriptor into the final memory attributes. The attributes it produces are the memory type (strongly ordered, device or normal), a shareable flag, and the inner and outer cacheability. Two 32-bit control registers drive the conversion. The type register picks a memory type for each value of the 3-bit index {TEX[0], C, B} and holds four remap bits for the shareable flag. The cache register holds an inner and an outer cacheability code for each index. The lookup runs in two stages. Stage one reads the type register to get the type and the shareable flag. Stage two applies the cache register only when stage one returns normal memory.

Each register has a secure copy and a nonsecure copy. A register port reads and writes the copy that matches the security state of the access. The port flags as undefined any access made in user mode, and any secure write made while the external lock input is high. Two mode bits, MMU-enable and remap-enable, choose the source of the attributes. When the two bits are equal, the block remaps: it uses the descriptor index if MMU-enable is 1 and the default-region index if it is 0. When the two bits differ, the attributes supplied on the pass-through inputs go to the outputs unchanged. The lookup is combinational. A register write takes effect at the next clock edge.

Top module: `attr_remap_unit`

## Requirements
- R1: After reset, both copies of the type register read 0x00098AA4 and both copies of the cache register read 0x44E048E0.
- R2: A legal access has acc_valid=1 and acc_priv=1 and is not a locked secure write. A legal write with acc_sel=0 loads the type register and with acc_sel=1 loads the cache register, in the copy selected by acc_secure (1 = secure). The new value is readable from the cycle after the write edge. The other copy does not change. A legal read returns the selected copy on acc_rdata in the same cycle.
- R3: Bits [31:20] of the type register always read as zero, whatever value was written.
- R4: acc_undef is high for any valid access with acc_priv=0. It is also high for a valid write with acc_secure=1 and acc_priv=1 while wr_lock=1. Such an access changes no register. A nonsecure privileged write is still accepted while wr_lock=1.
- R5: acc_rdata is zero whenever the access is a write, is not valid, or raises acc_undef.
- R6: With mmu_en equal to remap_en, the outputs are remapped. The index is desc_idx/desc_s when mmu_en=1 and dflt_idx/dflt_s when mmu_en=0. With mmu_en different from remap_en, mem_type, mem_shr, mem_inner and mem_outer equal pass_type, pass_shr, pass_inner and pass_outer unchanged.
- R7: When remapping, mem_type is type-register bits [2n+1:2n] for index n. The type encoding is 00 strongly ordered, 01 device and 10 normal. A field value of 11 is output as 10.
- R8: When remapping, the shareable output depends on the type. For normal memory it is type-register bit 19 when S=1 and bit 18 when S=0. For device memory it is bit 17 when S=1 and bit 16 when S=0. For strongly ordered memory it is 1.
- R9: When the remapped type is normal, mem_inner is cache-register bits [2n+1:2n] and mem_outer is bits [2n+17:2n+16]. The cache encoding is 00 noncacheable, 01 write-back with write allocate, 10 write-through and 11 write-back without write allocate.
- R10: When the remapped type is device or strongly ordered, mem_inner and mem_outer are both 00.
- R11: The remap lookup uses the register copy selected by lk_secure (1 = secure).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = type register, 1 = cache register |
| acc_secure | input | 1 | Security state of the access (1 = secure) |
| acc_priv | input | 1 | Privilege of the access (1 = privileged) |
| wr_lock | input | 1 | Blocks secure writes when high |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| acc_undef | output | 1 | Access is illegal |
| mmu_en | input | 1 | Mode bit: translation enabled |
| remap_en | input | 1 | Mode bit: remap enabled |
| lk_secure | input | 1 | Register copy used by the lookup |
| desc_idx | input | 3 | Descriptor {TEX[0],C,B} |
| desc_s | input | 1 | Descriptor shareable bit |
| dflt_idx | input | 3 | Default-region {TEX[0],C,B} |
| dflt_s | input | 1 | Default-region shareable bit |
| pass_type | input | 2 | Unremapped memory type |
| pass_shr | input | 1 | Unremapped shareable flag |
| pass_inner | input | 2 | Unremapped inner cacheability |
| pass_outer | input | 2 | Unremapped outer cacheability |
| mem_type | output | 2 | Final memory type |
| mem_shr | output | 1 | Final shareable flag |
| mem_inner | output | 2 | Final inner cacheability |
| mem_outer | output | 2 | Final outer cacheability |

## Verification
The properties assume that every input is stable and known around each rising edge. They also assume that the mode, index and pass-through inputs are meaningful in every cycle, because the lookup outputs are checked each cycle and not only when a consumer reads them. The stimulus changes every input one time unit after a rising edge and holds it until the next edge, and it drives all inputs to defined values from reset onward. The register-content checks rely on the bench's own register model. The bench updates that model only for accesses that R4 allows, so the expected values stay valid across locked and user-mode attempts.

// File: rtl/attr_remap_pkg.sv
package attr_remap_pkg;

    parameter int unsigned REG_W  = 32;
    parameter int unsigned IDX_W  = 3;
    parameter int unsigned ATTR_W = 2;

    localparam int unsigned N_IDX       = 1 << IDX_W;
    localparam int unsigned SHR_BASE    = ATTR_W * N_IDX;
    localparam int unsigned PRIM_USED_W = SHR_BASE + 4;
    localparam int unsigned OUTER_LSB   = REG_W / 2;

    // Offsets of the shareable remap bits above SHR_BASE
    localparam int unsigned SHR_DEV_S0  = 0;
    localparam int unsigned SHR_DEV_S1  = 1;
    localparam int unsigned SHR_NORM_S0 = 2;
    localparam int unsigned SHR_NORM_S1 = 3;

    typedef enum logic [ATTR_W-1:0] {
        MT_SO   = 2'b00,
        MT_DEV  = 2'b01,
        MT_NORM = 2'b10,
        MT_RSVD = 2'b11
    } mem_type_e;

    typedef struct packed {
        logic [ATTR_W-1:0] mtype;
        logic              shr;
        logic [ATTR_W-1:0] inner;
        logic [ATTR_W-1:0] outer;
    } mem_attr_t;

    typedef struct packed {
        logic [REG_W-1:0] prim;
        logic [REG_W-1:0] norm;
    } remap_bank_t;

    localparam logic [REG_W-1:0] PRIM_RST = 32'h0009_8AA4;
    localparam logic [REG_W-1:0] NORM_RST = 32'h44E0_48E0;
    localparam logic [REG_W-1:0] PRIM_WMASK =
        {{(REG_W-PRIM_USED_W){1'b0}}, {PRIM_USED_W{1'b1}}};

endpackage

// File: rtl/remap_access_chk.sv
module remap_access_chk (
    input  logic acc_valid,
    input  logic acc_write,
    input  logic acc_secure,
    input  logic acc_priv,
    input  logic wr_lock,
    output logic grant_rd,
    output logic grant_wr,
    output logic undef
);
    logic user_fault;
    logic lock_fault;

    always_comb begin
        user_fault = acc_valid && !acc_priv;
        lock_fault = acc_valid && acc_priv && acc_write && acc_secure && wr_lock;
        undef      = user_fault || lock_fault;
        grant_rd   = acc_valid && !acc_write && !undef;
        grant_wr   = acc_valid && acc_write && !undef;
    end
endmodule

// File: rtl/remap_regbank.sv
module remap_regbank
    import attr_remap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_rd,
    input  logic             grant_wr,
    input  logic             acc_sel,
    input  logic             acc_secure,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    output remap_bank_t      bank_sec,
    output remap_bank_t      bank_nsec
);
    typedef struct packed {
        remap_bank_t [1:0] bank;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (grant_wr) begin
            if (acc_sel) begin
                st_d.bank[acc_secure].norm = acc_wdata;
            end else begin
                st_d.bank[acc_secure].prim = acc_wdata & PRIM_WMASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                st_q.bank[b].prim <= PRIM_RST;
                st_q.bank[b].norm <= NORM_RST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (grant_rd) begin
            acc_rdata = acc_sel ? st_q.bank[acc_secure].norm
                                : st_q.bank[acc_secure].prim;
        end
    end

    assign bank_sec  = st_q.bank[1];
    assign bank_nsec = st_q.bank[0];
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
    import attr_remap_pkg::*;
(
    input  logic [PRIM_USED_W-1:0] prim_i,
    input  logic [REG_W-1:0]       norm_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic                   s_i,
    output mem_attr_t              attr_o
);
    logic [ATTR_W-1:0] type_tbl  [N_IDX];
    logic [ATTR_W-1:0] inner_tbl [N_IDX];
    logic [ATTR_W-1:0] outer_tbl [N_IDX];

    for (genvar gi = 0; gi < N_IDX; gi++) begin : g_fld
        assign type_tbl[gi]  = prim_i[ATTR_W*gi +: ATTR_W];
        assign inner_tbl[gi] = norm_i[ATTR_W*gi +: ATTR_W];
        assign outer_tbl[gi] = norm_i[OUTER_LSB + ATTR_W*gi +: ATTR_W];
    end

    logic [ATTR_W-1:0] stage1_type;

    always_comb begin
        // Stage one: memory type and shareability
        stage1_type = type_tbl[idx_i];
        if (stage1_type == MT_RSVD) begin
            stage1_type = MT_NORM;
        end
        attr_o.mtype = stage1_type;
        attr_o.inner = '0;
        attr_o.outer = '0;
        unique case (stage1_type)
            MT_SO:   attr_o.shr = 1'b1;
            MT_DEV:  attr_o.shr = s_i ? prim_i[SHR_BASE + SHR_DEV_S1]
                                      : prim_i[SHR_BASE + SHR_DEV_S0];
            default: attr_o.shr = s_i ? prim_i[SHR_BASE + SHR_NORM_S1]
                                      : prim_i[SHR_BASE + SHR_NORM_S0];
        endcase
        // Stage two: cacheability only for normal memory
        if (stage1_type == MT_NORM) begin
            attr_o.inner = inner_tbl[idx_i];
            attr_o.outer = outer_tbl[idx_i];
        end
    end
endmodule

// File: rtl/attr_remap_unit.sv
module attr_remap_unit
    import attr_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_sel,
    input  logic              acc_secure,
    input  logic              acc_priv,
    input  logic              wr_lock,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [REG_W-1:0]  acc_rdata,
    output logic              acc_undef,
    input  logic              mmu_en,
    input  logic              remap_en,
    input  logic              lk_secure,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic              desc_s,
    input  logic [IDX_W-1:0]  dflt_idx,
    input  logic              dflt_s,
    input  logic [ATTR_W-1:0] pass_type,
    input  logic              pass_shr,
    input  logic [ATTR_W-1:0] pass_inner,
    input  logic [ATTR_W-1:0] pass_outer,
    output logic [ATTR_W-1:0] mem_type,
    output logic              mem_shr,
    output logic [ATTR_W-1:0] mem_inner,
    output logic [ATTR_W-1:0] mem_outer
);
    logic        grant_rd, grant_wr;
    remap_bank_t bank_sec, bank_nsec, bank_lk;
    logic [IDX_W-1:0] lk_idx;
    logic        lk_s;
    logic        remap_on;
    mem_attr_t   remap_attr, final_attr;

    remap_access_chk u_chk (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_secure(acc_secure),
        .acc_priv  (acc_priv),
        .wr_lock   (wr_lock),
        .grant_rd  (grant_rd),
        .grant_wr  (grant_wr),
        .undef     (acc_undef)
    );

    remap_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_rd  (grant_rd),
        .grant_wr  (grant_wr),
        .acc_sel   (acc_sel),
        .acc_secure(acc_secure),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .bank_sec  (bank_sec),
        .bank_nsec (bank_nsec)
    );

    always_comb begin
        remap_on = (mmu_en == remap_en);
        lk_idx   = mmu_en ? desc_idx : dflt_idx;
        lk_s     = mmu_en ? desc_s   : dflt_s;
        bank_lk  = lk_secure ? bank_sec : bank_nsec;
    end

    remap_lookup u_look (
        .prim_i(bank_lk.prim[PRIM_USED_W-1:0]),
        .norm_i(bank_lk.norm),
        .idx_i (lk_idx),
        .s_i   (lk_s),
        .attr_o(remap_attr)
    );

    always_comb begin
        if (remap_on) begin
            final_attr = remap_attr;
        end else begin
            final_attr.mtype = pass_type;
            final_attr.shr   = pass_shr;
            final_attr.inner = pass_inner;
            final_attr.outer = pass_outer;
        end
        mem_type  = final_attr.mtype;
        mem_shr   = final_attr.shr;
        mem_inner = final_attr.inner;
        mem_outer = final_attr.outer;
    end
endmodule

// File: rtl/attr_remap_chk.sv
module attr_remap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_sel,
    input logic        acc_secure,
    input logic        acc_priv,
    input logic        wr_lock,
    input logic [31:0] acc_rdata,
    input logic        acc_undef,
    input logic        mmu_en,
    input logic        remap_en,
    input logic [1:0]  pass_type,
    input logic        pass_shr,
    input logic [1:0]  pass_inner,
    input logic [1:0]  pass_outer,
    input logic [1:0]  mem_type,
    input logic        mem_shr,
    input logic [1:0]  mem_inner,
    input logic [1:0]  mem_outer
);
    // R4
    user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv) |-> acc_undef);

    // R4
    lock_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_secure && acc_priv && wr_lock) |-> acc_undef);

    // R5
    undef_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_undef || acc_write || !acc_valid) |-> (acc_rdata == 32'h0));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_sel && !acc_undef) |-> (acc_rdata[31:20] == 12'h0));

    // R7
    no_rsvd_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_en == remap_en) |-> (mem_type != 2'b11));

    // R8
    so_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mmu_en == remap_en) && mem_type == 2'b00) |-> mem_shr);

    // R10
    noncache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mmu_en == remap_en) && mem_type != 2'b10) |-> (mem_inner == 2'b00 && mem_outer == 2'b00));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_en != remap_en) |-> (mem_type == pass_type && mem_shr == pass_shr &&
                                  mem_inner == pass_inner && mem_outer == pass_outer));
endmodule

bind attr_remap_unit attr_remap_chk i_attr_remap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .acc_secure(acc_secure),
    .acc_priv  (acc_priv),
    .wr_lock   (wr_lock),
    .acc_rdata (acc_rdata),
    .acc_undef (acc_undef),
    .mmu_en    (mmu_en),
    .remap_en  (remap_en),
    .pass_type (pass_type),
    .pass_shr  (pass_shr),
    .pass_inner(pass_inner),
    .pass_outer(pass_outer),
    .mem_type  (mem_type),
    .mem_shr   (mem_shr),
    .mem_inner (mem_inner),
    .mem_outer (mem_outer)
);

// File: tb/test_attr_remap_unit.sv
module test_attr_remap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_sel = 1'b0;
    logic        acc_secure = 1'b0, acc_priv = 1'b0, wr_lock = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_undef;
    logic        mmu_en = 1'b1, remap_en = 1'b1, lk_secure = 1'b0;
    logic [2:0]  desc_idx = '0, dflt_idx = '0;
    logic        desc_s = 1'b0, dflt_s = 1'b0;
    logic [1:0]  pass_type = '0, pass_inner = '0, pass_outer = '0;
    logic        pass_shr = 1'b0;
    logic [1:0]  mem_type, mem_inner, mem_outer;
    logic        mem_shr;

    always #10 clk = ~clk;

    attr_remap_unit i_attr_remap_unit (.*);

    typedef struct {
        string       tag;
        logic [39:0] exp;
        logic [39:0] mask;
    } item_t;

    item_t       sb_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;
    logic [31:0] ref_prim [2];
    logic [31:0] ref_norm [2];

    wire [39:0] obs = {acc_undef, acc_rdata, mem_type, mem_shr, mem_inner, mem_outer};

    localparam logic [39:0] ACC_MASK  = {1'b1, 32'hFFFF_FFFF, 7'h00};
    localparam logic [39:0] FULL_MASK = {40{1'b1}};

    function automatic logic [6:0] ref_look(input logic [31:0] p, input logic [31:0] n,
                                            input logic [2:0] i, input logic s);
        logic [1:0] t;
        logic       sh;
        logic [1:0] ci, co;
        t  = p[2*i +: 2];
        if (t == 2'b11) t = 2'b10;
        ci = 2'b00;
        co = 2'b00;
        if (t == 2'b00)      sh = 1'b1;
        else if (t == 2'b01) sh = s ? p[17] : p[16];
        else begin
            sh = s ? p[19] : p[18];
            ci = n[2*i +: 2];
            co = n[16 + 2*i +: 2];
        end
        return {t, sh, ci, co};
    endfunction

    task automatic push(input string tag, input logic [39:0] exp, input logic [39:0] mask);
        item_t it;
        it.tag = tag; it.exp = exp; it.mask = mask;
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge, halfway between driver updates
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, obs & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic access(input bit wr, input bit sel, input bit sec, input bit priv,
                          input bit lock, input logic [31:0] wd, input string tag);
        bit          legal;
        logic [31:0] rd;
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = wr; acc_sel = sel; acc_secure = sec;
        acc_priv = priv; wr_lock = lock; acc_wdata = wd;
        legal = priv && !(wr && sec && lock);
        rd = (legal && !wr) ? (sel ? ref_norm[sec] : ref_prim[sec]) : 32'h0;
        push(tag, {~legal, rd, 7'h00}, ACC_MASK);
        if (legal && wr) begin
            if (sel) ref_norm[sec] = wd;
            else     ref_prim[sec] = wd & 32'h000F_FFFF;
        end
    endtask

    task automatic look(input bit mmu, input bit rmp, input bit lsec,
                        input logic [2:0] di, input bit ds, input logic [2:0] fi, input bit fs,
                        input logic [6:0] pass, input string tag);
        logic [6:0] e;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; wr_lock = 1'b0;
        mmu_en = mmu; remap_en = rmp; lk_secure = lsec;
        desc_idx = di; desc_s = ds; dflt_idx = fi; dflt_s = fs;
        {pass_type, pass_shr, pass_inner, pass_outer} = pass;
        if (mmu == rmp) e = mmu ? ref_look(ref_prim[lsec], ref_norm[lsec], di, ds)
                                : ref_look(ref_prim[lsec], ref_norm[lsec], fi, fs);
        else            e = pass;
        push(tag, {1'b0, 32'h0, e}, FULL_MASK);
    endtask

    task automatic sweep(input bit lsec, input string tag);
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 2; s++) begin
                look(1'b1, 1'b1, lsec, 3'(i), s[0], 3'(7 - i), 1'b0, 7'h00, tag);
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] prim_pat [3];
        logic [31:0] norm_pat [3];
        prim_pat[0] = 32'h0005_1B4E; norm_pat[0] = 32'hA5C3_3C5A;
        prim_pat[1] = 32'hFFFA_E4D1; norm_pat[1] = 32'h1234_FEDC;
        prim_pat[2] = 32'h0003_0F0F; norm_pat[2] = 32'hFFFF_0000;
        for (int b = 0; b < 2; b++) begin
            ref_prim[b] = 32'h0009_8AA4;
            ref_norm[b] = 32'h44E0_48E0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents of both copies
        access(0, 0, 0, 1, 0, 0, "R1 ns type reset");
        access(0, 1, 0, 1, 0, 0, "R1 ns cache reset");
        access(0, 0, 1, 1, 0, 0, "R1 s type reset");
        access(0, 1, 1, 1, 0, 0, "R1 s cache reset");
        // R7 R8 R9 R10: reset lookup over all indices
        sweep(1'b0, "R7/R8/R9/R10 reset sweep");

        // R2 R3: write all ones to nonsecure type register
        access(1, 0, 0, 1, 0, 32'hFFFF_FFFF, "R5 write rdata zero");
        access(0, 0, 0, 1, 0, 0, "R3 reserved bits read zero");
        access(0, 0, 1, 1, 0, 0, "R2 secure copy untouched");
        // R11: reserved type code 11 in nonsecure copy, reset in secure
        sweep(1'b0, "R7 code 11 as normal");
        sweep(1'b1, "R11 secure copy lookup");

        for (int k = 0; k < 3; k++) begin
            access(1, 0, 0, 1, 0, prim_pat[k], "R2 type write");
            access(1, 1, 0, 1, 0, norm_pat[k], "R2 cache write");
            access(0, 0, 0, 1, 0, 0, "R2 type readback");
            access(0, 1, 0, 1, 0, 0, "R2 cache readback");
            sweep(1'b0, "R8/R9/R10 pattern sweep");
        end

        // R4 R5: user mode accesses
        access(0, 0, 0, 0, 0, 0, "R4 user read undef");
        access(1, 1, 0, 0, 0, 32'hDEAD_BEEF, "R4 user write undef");
        access(0, 1, 0, 1, 0, 0, "R4 user write ignored");
        // R4: locked secure write
        access(1, 0, 1, 1, 1, 32'h000F_FFFF, "R4 locked secure write undef");
        access(0, 0, 1, 1, 1, 0, "R4 locked secure read allowed");
        access(1, 1, 0, 1, 1, 32'h5555_AAAA, "R4 nonsecure write under lock");
        access(0, 1, 0, 1, 1, 0, "R4 nonsecure write landed");
        access(1, 1, 1, 1, 0, 32'h0F0F_3C3C, "R2 secure cache write");
        access(0, 1, 1, 1, 0, 0, "R2 secure cache readback");
        access(0, 1, 0, 1, 0, 0, "R2 nonsecure copy kept");
        sweep(1'b1, "R11 secure lookup after write");

        // R6: mode selection
        for (int i = 0; i < 8; i++) begin
            look(0, 0, 0, 3'(7 - i), 1'b1, 3'(i), 1'b0, 7'h00, "R6 remapped default index");
            look(0, 0, 1, 3'(7 - i), 1'b0, 3'(i), 1'b1, 7'h00, "R6 remapped default index s");
        end
        look(0, 1, 0, 3'd1, 1'b0, 3'd2, 1'b0, 7'b11_1_01_10, "R6 pass default");
        look(1, 0, 1, 3'd3, 1'b1, 3'd4, 1'b0, 7'b00_0_11_11, "R6 pass descriptor");
        look(1, 0, 0, 3'd5, 1'b1, 3'd6, 1'b1, 7'b01_1_10_01, "R6 pass descriptor 2");

        @(posedge clk); #1;
        acc_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule